// File: doc/BRIEF.md
# Supply Monitor Reset Controller

This block holds the control logic for two supply-voltage monitors. Monitor 0 watches the selected core supply. Monitor 1 watches the battery input. The block takes four raw comparator outputs: one below-reset-threshold and one below-warning-threshold output for each monitor. It passes them through a two-stage synchronizer. It keeps an enable, reset-source-select and interrupt-enable bit for each monitor. From these it drives the active-low system reset, a one-hot reset-cause register, a RAM-invalid indication, a supply-OK flag per monitor and an interrupt per monitor.

A monitor counts as active when it is enabled and the device is awake. An active monitor that is also selected holds the system in reset while its supply is low. Every reset is stretched by a fixed count of cycles after its last cause goes away. The monitor configuration survives software resets, flash-error resets and sleep. Only power-on and power-fail resets put it back to its default. A flash erase or write requested while the core monitor is disabled is refused and turned into a flash-error reset.

Top module: `supmon_rst_ctrl`

## Requirements
- R1: While `por_n` is low and after it rises, `cfg_state` reads 6'b000011. Bit 0 is core enable, bit 1 core select, bit 2 battery enable, bit 3 battery select, bit 4 core interrupt enable and bit 5 battery interrupt enable. `rst_cause` reads 3'b001 and `ram_invalid` is 1. `sys_rst_n` goes high on the 16th rising edge after `por_n` rises.
- R2: A below-reset input of an active, selected monitor pulls `sys_rst_n` low. It does so on the third rising edge after the input changes (two synchronizer stages, then the reset register). The reset stays low for as long as the input stays high.
- R3: Reset is released only after 16 consecutive cycles free of any reset condition. `sys_rst_n` goes high on the 17th rising edge after a one-cycle software or flash request. It goes high on the 18th rising edge after a below-reset input falls.
- R4: When a power-fail reset is released, `cfg_state` returns to 6'b000011. `rst_cause` then reads 3'b001 (bit 0 power-on/power-fail, bit 1 software, bit 2 flash error) and `ram_invalid` is 1.
- R5: A one-cycle `sw_reset_req` asserts reset. It sets `rst_cause` to 3'b010 and clears `ram_invalid`. It leaves `cfg_state` unchanged.
- R6: After `sleep_req`, neither monitor is active. Below-reset inputs cause no reset, and both OK flags read 1. After `wake_req`, the configuration last written applies again.
- R7: The OK flag of an active monitor is the inverse of its synchronized below-warning input. An inactive monitor reads OK. The flag follows its input three rising edges after the input changes.
- R8: A monitor's interrupt is high exactly when its OK flag is 0 and its interrupt enable is set.
- R9: `flash_grant` is high in the same cycle as `flash_req` when the core monitor is enabled and reset is not asserted. If `flash_req` comes while the core monitor is disabled, the grant stays low and a reset follows with `rst_cause` 3'b100. `cfg_state` is unchanged.
- R10: A set select bit has no effect on reset generation while its monitor's enable bit is clear.
- R11: Configuration writes made while `sys_rst_n` is low are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| core_below_rst | input | 1 | Raw core comparator output: below the reset threshold |
| core_below_warn | input | 1 | Raw core comparator output: below the warning threshold |
| batt_below_rst | input | 1 | Raw battery comparator output: below the reset threshold |
| batt_below_warn | input | 1 | Raw battery comparator output: below the warning threshold |
| sw_reset_req | input | 1 | Software reset request, one-cycle pulse |
| sleep_req | input | 1 | Enter sleep, one-cycle pulse |
| wake_req | input | 1 | Leave sleep, one-cycle pulse |
| flash_req | input | 1 | Flash erase or write request |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 6 | Configuration value, field layout as in R1 |
| sys_rst_n | output | 1 | System reset, active low |
| rst_cause | output | 3 | One-hot cause of the last reset |
| ram_invalid | output | 1 | RAM contents lost with the last reset |
| cfg_state | output | 6 | Configuration as last written or defaulted |
| core_ok | output | 1 | Core supply above the warning threshold |
| batt_ok | output | 1 | Battery supply above the warning threshold |
| core_irq | output | 1 | Core supply warning interrupt |
| batt_irq | output | 1 | Battery supply warning interrupt |
| flash_grant | output | 1 | Flash operation allowed |

## Verification
The hardest state to reach is a monitor that is enabled and selected, sees its supply low, and yet must not reset the system because the device is asleep. After wake the same monitor has to act again with its old configuration. The stimulus writes a configuration with both monitors enabled and selected, enters sleep, and then raises every comparator input. It lowers the inputs before waking and confirms that the configuration is unchanged. It then checks that a warning input takes effect once more. Exact release timing is checked separately after a software pulse and after a below-reset input falls, because the synchronizer adds one edge to the second case.

// File: rtl/supmon_pkg.sv
package supmon_pkg;

  localparam int NMON = 2;
  localparam int MON_CORE = 0;
  localparam int MON_BATT = 1;

  localparam int CAUSE_W = 3;
  localparam int CAUSE_PF = 0;
  localparam int CAUSE_SW = 1;
  localparam int CAUSE_FLASH = 2;

  typedef struct packed {
    logic batt_ie;
    logic core_ie;
    logic batt_sel;
    logic batt_en;
    logic core_sel;
    logic core_en;
  } mon_cfg_t;

  localparam int CFG_W = $bits(mon_cfg_t);
  localparam mon_cfg_t CFG_DEFAULT = 6'b000011;

  // a monitor is live when enabled and the device is awake
  function automatic logic mon_live(input logic en, input logic asleep);
    return en & ~asleep;
  endfunction

  // a live, selected monitor with its supply low demands reset
  function automatic logic mon_fires(input logic live, input logic sel,
                                     input logic below);
    return live & sel & below;
  endfunction

  // next OK flag: an idle monitor reports OK
  function automatic logic ok_next(input logic live, input logic warn);
    return live ? ~warn : 1'b1;
  endfunction

  // reset cause chosen for a new reset event, power-fail first
  function automatic logic [CAUSE_W-1:0] cause_pick(input logic pf,
                                                    input logic flash_err);
    logic [CAUSE_W-1:0] c;
    c = '0;
    if (pf) c[CAUSE_PF] = 1'b1;
    else if (flash_err) c[CAUSE_FLASH] = 1'b1;
    else c[CAUSE_SW] = 1'b1;
    return c;
  endfunction

endpackage

// File: rtl/supmon_sync.sv
module supmon_sync #(
  parameter int W = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/supmon_channel.sv
module supmon_channel
  import supmon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic sel,
  input  logic ie,
  input  logic asleep,
  input  logic below_rst_s,
  input  logic below_warn_s,
  output logic fire,
  output logic ok,
  output logic irq
);
  logic live;

  assign live = mon_live(en, asleep);
  assign fire = mon_fires(live, sel, below_rst_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ok <= 1'b1;
    else ok <= ok_next(live, below_warn_s);
  end

  assign irq = ie & ~ok;

  // R7: an idle monitor reports OK on the next cycle
  a_r7_idle_ok: assert property (@(posedge clk) disable iff (!rst_n)
    !live |=> ok);
  // R8: an interrupt needs a warning seen one cycle earlier
  a_r8_irq_from_warn: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(below_warn_s));
  // R10: a disabled monitor never demands reset
  a_r10_sel_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !fire);
endmodule

// File: rtl/supmon_rst_seq.sv
module supmon_rst_seq
  import supmon_pkg::*;
#(
  parameter int STRETCH = 16
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               pf_cond,
  input  logic               flash_err,
  input  logic               sw_req,
  output logic               rst_active,
  output logic [CAUSE_W-1:0] cause,
  output logic               pf_release
);
  localparam int CNT_W = $clog2(STRETCH + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STRETCH - 1);

  logic [CNT_W-1:0] cnt;
  logic             pf_seen;
  logic             any_cond;
  logic             done;

  assign any_cond = pf_cond | flash_err | sw_req;
  assign done = rst_active && !any_cond && (cnt == CNT_LAST);
  assign pf_release = done && pf_seen;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_active <= 1'b1;
      cnt <= '0;
      cause <= CAUSE_W'(1 << CAUSE_PF);
      pf_seen <= 1'b0;
    end else if (any_cond) begin
      rst_active <= 1'b1;
      cnt <= '0;
      pf_seen <= (rst_active & pf_seen) | pf_cond;
      if (!(rst_active && pf_seen)) cause <= cause_pick(pf_cond, flash_err);
    end else if (rst_active) begin
      if (cnt == CNT_LAST) begin
        rst_active <= 1'b0;
        pf_seen <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  // R2: any reset condition holds reset on the next cycle
  a_r2_cond_holds: assert property (@(posedge clk) disable iff (!por_n)
    any_cond |=> rst_active);
  // R3: reset never releases right after a live condition
  a_r3_no_early_release: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_active) |-> $past(!any_cond));
  // R4: a power-fail episode leaves the power-fail cause behind
  a_r4_pf_cause: assert property (@(posedge clk) disable iff (!por_n)
    pf_release |=> cause[CAUSE_PF]);
  // R1: the cause register stays one-hot
  a_r1_cause_onehot: assert property (@(posedge clk) disable iff (!por_n)
    $countones(cause) == 1);
endmodule

// File: rtl/supmon_rst_ctrl.sv
module supmon_rst_ctrl
  import supmon_pkg::*;
#(
  parameter int STRETCH = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               core_below_rst,
  input  logic               core_below_warn,
  input  logic               batt_below_rst,
  input  logic               batt_below_warn,
  input  logic               sw_reset_req,
  input  logic               sleep_req,
  input  logic               wake_req,
  input  logic               flash_req,
  input  logic               cfg_we,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic               sys_rst_n,
  output logic [CAUSE_W-1:0] rst_cause,
  output logic               ram_invalid,
  output logic [CFG_W-1:0]   cfg_state,
  output logic               core_ok,
  output logic               batt_ok,
  output logic               core_irq,
  output logic               batt_irq,
  output logic               flash_grant
);
  localparam int RAW_W = 2 * NMON;

  mon_cfg_t          cfg_q;
  logic              asleep;
  logic              rst_active;
  logic              pf_release;
  logic              flash_err;
  logic              pf_cond;
  logic [RAW_W-1:0]  raw_in;
  logic [RAW_W-1:0]  syn_in;
  logic [NMON-1:0]   m_en, m_sel, m_ie, m_fire, m_ok, m_irq;
  logic [NMON-1:0]   m_below, m_warn;

  assign raw_in = {batt_below_warn, core_below_warn, batt_below_rst, core_below_rst};

  supmon_sync #(.W(RAW_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(por_n), .d(raw_in), .q(syn_in)
  );

  assign m_below = syn_in[NMON-1:0];
  assign m_warn = syn_in[RAW_W-1:NMON];
  assign m_en = {cfg_q.batt_en, cfg_q.core_en};
  assign m_sel = {cfg_q.batt_sel, cfg_q.core_sel};
  assign m_ie = {cfg_q.batt_ie, cfg_q.core_ie};

  for (genvar g = 0; g < NMON; g++) begin : g_mon
    supmon_channel u_ch (
      .clk(clk), .rst_n(por_n), .en(m_en[g]), .sel(m_sel[g]), .ie(m_ie[g]),
      .asleep(asleep), .below_rst_s(m_below[g]), .below_warn_s(m_warn[g]),
      .fire(m_fire[g]), .ok(m_ok[g]), .irq(m_irq[g])
    );
  end

  assign pf_cond = |m_fire;
  assign flash_err = flash_req && !cfg_q.core_en && !rst_active;
  assign flash_grant = flash_req && cfg_q.core_en && !rst_active;

  supmon_rst_seq #(.STRETCH(STRETCH)) u_seq (
    .clk(clk), .por_n(por_n), .pf_cond(pf_cond), .flash_err(flash_err),
    .sw_req(sw_reset_req), .rst_active(rst_active), .cause(rst_cause),
    .pf_release(pf_release)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) cfg_q <= CFG_DEFAULT;
    else if (pf_release) cfg_q <= CFG_DEFAULT;
    else if (cfg_we && !rst_active) cfg_q <= mon_cfg_t'(cfg_wdata);
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) asleep <= 1'b0;
    else if (pf_release) asleep <= 1'b0;
    else if (sleep_req && !rst_active) asleep <= 1'b1;
    else if (wake_req) asleep <= 1'b0;
  end

  assign sys_rst_n = ~rst_active;
  assign ram_invalid = rst_cause[CAUSE_PF];
  assign cfg_state = cfg_q;
  assign core_ok = m_ok[MON_CORE];
  assign batt_ok = m_ok[MON_BATT];
  assign core_irq = m_irq[MON_CORE];
  assign batt_irq = m_irq[MON_BATT];

  // R11: configuration is frozen while reset is held, except power-fail default
  a_r11_cfg_frozen: assert property (@(posedge clk) disable iff (!por_n)
    (rst_active && !pf_release) |=> $stable(cfg_q));
  // R9: unprotected flash request forces reset next cycle
  a_r9_flash_reset: assert property (@(posedge clk) disable iff (!por_n)
    (flash_req && !cfg_q.core_en && sys_rst_n) |=> !sys_rst_n);
  // R6: no power-fail demand while asleep
  a_r6_sleep_quiet: assert property (@(posedge clk) disable iff (!por_n)
    asleep |-> !pf_cond);
  // R4: power-fail release restores the default configuration
  a_r4_cfg_default: assert property (@(posedge clk) disable iff (!por_n)
    pf_release |=> (cfg_q == CFG_DEFAULT));
endmodule

// File: tb/supmon_rst_ctrl_test.sv
module supmon_rst_ctrl_test;
  localparam int STRETCH = 16;
  localparam int SYNC = 2;
  localparam logic [5:0] DEF_CFG = 6'b000011;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic core_below_rst = 0, core_below_warn = 0, batt_below_rst = 0, batt_below_warn = 0;
  logic sw_reset_req = 0, sleep_req = 0, wake_req = 0, flash_req = 0, cfg_we = 0;
  logic [5:0] cfg_wdata = '0;
  logic sys_rst_n, ram_invalid, core_ok, batt_ok, core_irq, batt_irq, flash_grant;
  logic [2:0] rst_cause;
  logic [5:0] cfg_state;

  int vectors = 0;
  int miscompares = 0;

  always #10 clk = ~clk;

  supmon_rst_ctrl #(.STRETCH(STRETCH), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .por_n(por_n), .core_below_rst(core_below_rst),
    .core_below_warn(core_below_warn), .batt_below_rst(batt_below_rst),
    .batt_below_warn(batt_below_warn), .sw_reset_req(sw_reset_req),
    .sleep_req(sleep_req), .wake_req(wake_req), .flash_req(flash_req),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .sys_rst_n(sys_rst_n),
    .rst_cause(rst_cause), .ram_invalid(ram_invalid), .cfg_state(cfg_state),
    .core_ok(core_ok), .batt_ok(batt_ok), .core_irq(core_irq),
    .batt_irq(batt_irq), .flash_grant(flash_grant)
  );

  // release latencies in falling edges counted from the drive
  function automatic int lat_pulse();
    return STRETCH + 1;
  endfunction
  function automatic int lat_supply();
    return STRETCH + SYNC;
  endfunction
  function automatic logic exp_ok(input logic en, input logic warn);
    return !(en && warn);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_cfg(input logic [5:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    // R1: power-on state
    step(2);
    check("R1 rst during por", sys_rst_n, 0);
    check("R1 cfg default", cfg_state, DEF_CFG);
    check("R1 cause", rst_cause, 3'b001);
    check("R1 ram_invalid", ram_invalid, 1);
    por_n = 1'b1;
    step(STRETCH - 1);
    check("R1 still low", sys_rst_n, 0);
    step(1);
    check("R1 released", sys_rst_n, 1);

    // R2, R3, R4: power-fail on the core monitor
    wr_cfg(6'b010111);
    check("R4 cfg written", cfg_state, 6'b010111);
    core_below_rst = 1'b1;
    step(SYNC + 1);
    check("R2 pf asserts", sys_rst_n, 0);
    step(25);
    check("R2 pf held", sys_rst_n, 0);
    core_below_rst = 1'b0;
    step(lat_supply() - 1);
    check("R3 pf stretch low", sys_rst_n, 0);
    step(1);
    check("R3 pf released", sys_rst_n, 1);
    check("R4 cfg defaulted", cfg_state, DEF_CFG);
    check("R4 cause pf", rst_cause, 3'b001);
    check("R4 ram_invalid", ram_invalid, 1);

    // R5, R11: software reset keeps configuration, ignores writes in reset
    wr_cfg(6'b110101);
    sw_reset_req = 1'b1;
    step(1);
    sw_reset_req = 1'b0;
    check("R5 sw asserts", sys_rst_n, 0);
    wr_cfg(6'b000001);
    step(lat_pulse() - 3);
    check("R3 sw stretch low", sys_rst_n, 0);
    step(1);
    check("R3 sw released", sys_rst_n, 1);
    check("R5 cause sw", rst_cause, 3'b010);
    check("R5 ram valid", ram_invalid, 0);
    check("R11 write ignored", cfg_state, 6'b110101);

    // R10: select without enable
    wr_cfg(6'b001010);
    core_below_rst = 1'b1; batt_below_rst = 1'b1;
    step(8);
    check("R10 no reset", sys_rst_n, 1);
    core_below_rst = 1'b0; batt_below_rst = 1'b0;
    step(4);

    // R9: flash refused while core monitor disabled
    flash_req = 1'b1;
    #1;
    check("R9 no grant", flash_grant, 0);
    step(1);
    flash_req = 1'b0;
    check("R9 flash reset", sys_rst_n, 0);
    step(lat_pulse());
    check("R9 released", sys_rst_n, 1);
    check("R9 cause flash", rst_cause, 3'b100);
    check("R9 cfg kept", cfg_state, 6'b001010);
    wr_cfg(6'b000011);
    flash_req = 1'b1;
    #1;
    check("R9 grant", flash_grant, 1);
    step(1);
    flash_req = 1'b0;
    check("R9 no reset on grant", sys_rst_n, 1);

    // R6: sleep masks monitors, wake restores
    wr_cfg(6'b111111);
    sleep_req = 1'b1;
    step(1);
    sleep_req = 1'b0;
    core_below_rst = 1; batt_below_rst = 1; core_below_warn = 1; batt_below_warn = 1;
    step(8);
    check("R6 no reset asleep", sys_rst_n, 1);
    check("R6 core ok asleep", core_ok, 1);
    check("R6 batt ok asleep", batt_ok, 1);
    check("R8 no irq asleep", {batt_irq, core_irq}, 2'b00);
    core_below_rst = 0; batt_below_rst = 0; core_below_warn = 0; batt_below_warn = 0;
    step(4);
    wake_req = 1'b1;
    step(1);
    wake_req = 1'b0;
    check("R6 cfg restored", cfg_state, 6'b111111);
    batt_below_warn = 1'b1;
    step(SYNC + 1);
    check("R7 batt warn after wake", batt_ok, 0);
    check("R8 batt irq after wake", batt_irq, 1);
    batt_below_warn = 1'b0;
    step(SYNC + 1);
    check("R7 batt ok again", batt_ok, 1);

    // R7, R8: random configurations and warnings, no reset inputs
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 40; i++) begin
      logic [5:0] c;
      logic wc, wb;
      c = 6'($urandom());
      wc = 1'($urandom());
      wb = 1'($urandom());
      wr_cfg(c);
      core_below_warn = wc; batt_below_warn = wb;
      step(SYNC + 2);
      check("R7 core ok", core_ok, exp_ok(c[0], wc));
      check("R7 batt ok", batt_ok, exp_ok(c[2], wb));
      check("R8 core irq", core_irq, !exp_ok(c[0], wc) && c[4]);
      check("R8 batt irq", batt_irq, !exp_ok(c[2], wb) && c[5]);
      check("R10 random no reset", sys_rst_n, 1);
    end
    core_below_warn = 0; batt_below_warn = 0;
    step(2);
    report();
  end
endmodule